// File: doc/BRIEF.md
# Link-Side Receive Deformatter

This block sits at the link end of a PHY-to-link parallel interface and turns what the PHY drives while it receives into a clean packet byte stream. Every PHY-clock cycle it registers the two-bit control code, the low and high data lanes and the high-lane valid flag. A small state machine then finds the start-of-reception marker and captures any status bytes. It decodes the rate code and strips the formatting from the payload.

Slower rates hold each byte on the lane for a fixed group of clocks, and the block keeps only the first cycle of each group. At the fastest rate each cycle carries a byte pair, which the block splits into low-then-high order. The high byte of the final cycle is dropped when the PHY marks it invalid. The block knows from its own state when the high lane carries only expansion padding, so it never looks at that lane's value to decide. When the control code leaves the receive value, the block gives an end pulse with the number of payload bytes. A reserved rate code gives an error pulse, and the rest of that packet is thrown away.

The output is two bytes wide by default, which keeps up with paired cycles without stalls. A build option (`OUT_BYTES = 1`) gives a one-byte stream behind a two-entry skid buffer instead. That variant fits the slower rates and short paired packets.

States and transitions: `S_IDLE` goes to `S_HDR` when the control code steps from idle (00) to receive (10) with low byte FF. `S_HDR` stays put on further FF receive cycles and on status cycles (01). It goes to `S_BODY` on a defined rate code and to `S_DROP` on a reserved one. On any other control code it returns to `S_IDLE` without an end pulse. `S_BODY` and `S_DROP` both return to `S_IDLE` when the control code leaves receive. Only `S_BODY` produces the end pulse on that transition.

Top module: `rx_deformat`

## Requirements
- R1: After reset the outputs `out_vld`, `out_sop`, `out_eop`, `out_err` and `st_vld` are 0, and `out_rate` and `out_legacy` are 0.
- R2: Reception opens only when a control code of 10 with low byte FF follows a cycle with control code 00. A control code of 10 with any other low byte while idle produces no beat, no status and no end pulse.
- R3: Each control code 01 cycle between the opening marker and the rate code raises `st_vld` for one cycle, with that cycle's low byte on `st_byte`. This happens two clocks after the input cycle.
- R4: The first receive cycle after the marker whose low byte is not FF carries the rate code. The codes are decoded as follows, giving `out_rate`/`out_legacy`:
  - 00 gives 0/1 and 01 gives 0/0.
  - 04 gives 1/1 and 05 gives 1/0.
  - 08 gives 2/1 and 09 gives 2/0.
  - 0D gives 3/0, 0F gives 4/0 and 0B gives 5/0.
- R5: Any other rate code raises `out_err` for one cycle. The packet is then discarded: no beats and no end pulse until the control code leaves 10.
- R6: For `out_rate` 0, 1, 2 and 3, each byte occupies a group of 16, 8, 4 or 2 receive cycles, and only the first cycle of each group produces a beat. At `out_rate` 4, every receive cycle produces a beat.
- R7: At `out_rate` 5 each payload cycle produces one beat. `out_data[7:0]` holds the low-lane byte and `out_data[15:8]` holds the high-lane byte. Beats appear two clocks after the input cycle.
- R8: Outside payload cycles at `out_rate` 5, the high lane and the valid flag have no effect on any output.
- R9: At `out_rate` 5, `out_keep` is 11 when the valid flag is 1 and 01 when it is 0, and the byte count follows `out_keep`. At every other rate `out_keep` is 01.
- R10: When the control code leaves 10 during a payload, `out_eop` pulses two clocks later. `out_len` then holds the number of payload bytes delivered.
- R11: `out_sop` is 1 on the first beat of a packet only.
- R12: If the control code leaves 10/01 after the marker and before a rate code, no end pulse and no error are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_ctl | input | 2 | Control code driven by the PHY |
| phy_dlo | input | 8 | Low data lane |
| phy_dhi | input | 8 | High data lane |
| phy_hvld | input | 1 | High-lane valid flag |
| out_vld | output | 1 | Payload beat valid |
| out_data | output | OUT_BYTES*8 | Beat bytes, earliest byte in bits 7:0 |
| out_keep | output | OUT_BYTES | Per-byte valid mask for the beat |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | End-of-packet pulse |
| out_len | output | LEN_W | Byte count, valid with `out_eop` |
| out_rate | output | 3 | Decoded rate index 0..5 |
| out_legacy | output | 1 | Decoded legacy-format flag |
| st_vld | output | 1 | Status byte valid |
| st_byte | output | 8 | Captured status byte |
| out_err | output | 1 | Reserved rate code pulse |

## Verification
The assertions assume that the PHY always passes through an idle cycle before it opens a reception, and that a packet ends by leaving the receive code rather than by an unbroken run of markers. In the one-byte variant they also assume that paired cycles are spaced so that the two-entry buffer never has to hold more than two bytes. The stimulus keeps to these rules: every sequence starts and ends with idle cycles, byte groups at slow rates are always complete, and only the two-byte default is driven with paired payloads. Within those limits the stimulus still places nonzero data on the high lane during header and slow-rate cycles, so that the padding rule is tested.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [1:0] CTL_IDLE = 2'b00;
    localparam logic [1:0] CTL_STAT = 2'b01;
    localparam logic [1:0] CTL_RECV = 2'b10;

    localparam logic [7:0] MARK_ON  = 8'hFF;

    // rate index 5 is the paired-lane rate; 0..4 use the low lane only
    localparam logic [2:0] RATE_PAIR = 3'd5;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HDR,
        S_BODY,
        S_DROP
    } rx_state_e;
endpackage

// File: rtl/rxd_sample.sv
module rxd_sample (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ctl_i,
    input  logic [7:0] lo_i,
    input  logic [7:0] hi_i,
    input  logic       hv_i,
    output logic [1:0] ctl_q,
    output logic [1:0] ctl_prev_q,
    output logic [7:0] lo_q,
    output logic [7:0] hi_q,
    output logic       hv_q
);
    timeunit 1ns;
    timeprecision 1ps;

    // one flop stage on every PHY-driven pin; previous control kept for edge detect
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= 2'b00;
            ctl_prev_q <= 2'b00;
            lo_q       <= 8'h00;
            hi_q       <= 8'h00;
            hv_q       <= 1'b0;
        end else begin
            ctl_q      <= ctl_i;
            ctl_prev_q <= ctl_q;
            lo_q       <= lo_i;
            hi_q       <= hi_i;
            hv_q       <= hv_i;
        end
    end
endmodule

// File: rtl/rxd_speed_dec.sv
module rxd_speed_dec (
    input  logic [7:0] code,
    output logic       ok,
    output logic [2:0] rate,
    output logic       legacy,
    output logic [3:0] rep_mask
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        ok     = 1'b1;
        rate   = 3'd0;
        legacy = 1'b0;
        unique case (code)
            8'h00: begin rate = 3'd0; legacy = 1'b1; end
            8'h01: begin rate = 3'd0; end
            8'h04: begin rate = 3'd1; legacy = 1'b1; end
            8'h05: begin rate = 3'd1; end
            8'h08: begin rate = 3'd2; legacy = 1'b1; end
            8'h09: begin rate = 3'd2; end
            8'h0D: begin rate = 3'd3; end
            8'h0F: begin rate = 3'd4; end
            8'h0B: begin rate = 3'd5; end
            default: ok = 1'b0;
        endcase
        // group length 16 >> rate for rate 0..4; one cycle per beat above that
        rep_mask = (rate < 3'd4) ? 4'((5'd16 >> rate) - 5'd1) : 4'd0;
    end
endmodule

// File: rtl/rxd_fsm.sv
module rxd_fsm
    import rxd_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       s_ctl,
    input  logic [1:0]       s_ctl_prev,
    input  logic [7:0]       s_lo,
    input  logic [7:0]       s_hi,
    input  logic             s_hv,
    output logic             beat_vld,
    output logic [15:0]      beat_data,
    output logic [1:0]       beat_keep,
    output logic             beat_sop,
    output logic             end_pls,
    output logic [LEN_W-1:0] end_len,
    output logic [2:0]       rate_q,
    output logic             legacy_q,
    output logic             stat_vld,
    output logic [7:0]       stat_byte,
    output logic             err_pls
);
    timeunit 1ns;
    timeprecision 1ps;

    rx_state_e state, state_nx;

    logic       code_ok, code_leg;
    logic [2:0] code_rate;
    logic [3:0] code_mask;
    logic [3:0] mask_q, ph_q;
    logic       first_q;
    logic [LEN_W-1:0] cnt_q;
    logic       is_recv, is_stat, is_mark;

    assign is_recv = (s_ctl == CTL_RECV);
    assign is_stat = (s_ctl == CTL_STAT);
    assign is_mark = (s_lo == MARK_ON);

    rxd_speed_dec u_dec (
        .code     (s_lo),
        .ok       (code_ok),
        .rate     (code_rate),
        .legacy   (code_leg),
        .rep_mask (code_mask)
    );

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (s_ctl_prev == CTL_IDLE && is_recv && is_mark) state_nx = S_HDR;
            S_HDR: begin
                if (is_recv) begin
                    if (!is_mark) state_nx = code_ok ? S_BODY : S_DROP;
                end else if (!is_stat) begin
                    state_nx = S_IDLE;
                end
            end
            S_BODY: if (!is_recv) state_nx = S_IDLE;
            S_DROP: if (!is_recv) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // registered outputs and payload bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_vld  <= 1'b0;
            beat_data <= 16'h0000;
            beat_keep <= 2'b00;
            beat_sop  <= 1'b0;
            end_pls   <= 1'b0;
            end_len   <= '0;
            rate_q    <= 3'd0;
            legacy_q  <= 1'b0;
            stat_vld  <= 1'b0;
            stat_byte <= 8'h00;
            err_pls   <= 1'b0;
            mask_q    <= 4'd0;
            ph_q      <= 4'd0;
            first_q   <= 1'b0;
            cnt_q     <= '0;
        end else begin
            beat_vld  <= 1'b0;
            beat_keep <= 2'b00;
            beat_sop  <= 1'b0;
            end_pls   <= 1'b0;
            stat_vld  <= 1'b0;
            err_pls   <= 1'b0;
            unique case (state)
                S_IDLE: ;
                S_HDR: begin
                    if (is_stat) begin
                        stat_vld  <= 1'b1;
                        stat_byte <= s_lo;
                    end else if (is_recv && !is_mark) begin
                        if (code_ok) begin
                            rate_q   <= code_rate;
                            legacy_q <= code_leg;
                            mask_q   <= code_mask;
                            ph_q     <= 4'd0;
                            first_q  <= 1'b1;
                            cnt_q    <= '0;
                        end else begin
                            err_pls  <= 1'b1;
                        end
                    end
                end
                S_BODY: begin
                    if (is_recv) begin
                        if (ph_q == 4'd0) begin
                            beat_vld <= 1'b1;
                            beat_sop <= first_q;
                            first_q  <= 1'b0;
                            if (rate_q == RATE_PAIR) begin
                                beat_data <= {s_hi, s_lo};
                                beat_keep <= {s_hv, 1'b1};
                                cnt_q     <= cnt_q + (s_hv ? LEN_W'(2) : LEN_W'(1));
                            end else begin
                                beat_data <= {8'h00, s_lo};
                                beat_keep <= 2'b01;
                                cnt_q     <= cnt_q + LEN_W'(1);
                            end
                        end
                        ph_q <= (ph_q + 4'd1) & mask_q;
                    end else begin
                        end_pls <= 1'b1;
                        end_len <= cnt_q;
                    end
                end
                S_DROP: ;
                default: ;
            endcase
        end
    end

    // R11: a start flag never appears without a beat
    a_r11_sop_with_beat: assert property (@(posedge clk) disable iff (!rst_n)
        beat_sop |-> beat_vld);

    // R5: once discarding, the next cycle carries no beat
    a_r5_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DROP) |=> !beat_vld);

    // R10: an end pulse only follows a payload state
    a_r10_eop_after_body: assert property (@(posedge clk) disable iff (!rst_n)
        end_pls |-> ($past(state) == S_BODY));

    // R12: abandoning the header gives no end pulse
    a_r12_hdr_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HDR && !is_recv && !is_stat) |=> (!end_pls && !err_pls));

    // R6 / R9: below the paired rate a beat holds exactly one byte
    a_r6_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && rate_q != RATE_PAIR) |-> (beat_keep == 2'b01));

    // R9: the low byte of any beat is always valid
    a_r9_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld |-> beat_keep[0]);
endmodule

// File: rtl/rxd_out.sv
module rxd_out #(
    parameter int OUT_BYTES = 2,
    parameter int LEN_W     = 16,
    localparam int DW       = OUT_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_vld,
    input  logic [15:0]      beat_data,
    input  logic [1:0]       beat_keep,
    input  logic             beat_sop,
    input  logic             end_pls,
    input  logic [LEN_W-1:0] end_len,
    output logic             out_vld,
    output logic [DW-1:0]    out_data,
    output logic [OUT_BYTES-1:0] out_keep,
    output logic             out_sop,
    output logic             out_eop,
    output logic [LEN_W-1:0] out_len
);
    timeunit 1ns;
    timeprecision 1ps;

    if (OUT_BYTES == 2) begin : g_pair
        assign out_vld  = beat_vld;
        assign out_data = beat_data;
        assign out_keep = beat_keep;
        assign out_sop  = beat_sop;
        assign out_eop  = end_pls;
        assign out_len  = end_len;

        // R9: a high byte is never marked without the low byte
        a_r9_keep_order: assert property (@(posedge clk) disable iff (!rst_n)
            beat_keep[1] |-> beat_keep[0]);
    end else begin : g_skid
        logic [8:0] q [2];
        logic [8:0] slots [4];
        logic [1:0] cnt_q;
        logic [1:0] rem;
        logic [2:0] cnt_nx;
        logic       pop;
        logic       eop_pend_q;
        logic [LEN_W-1:0] len_q;

        assign pop = (cnt_q != 2'd0);

        always_comb begin
            slots[0] = pop ? q[1] : q[0];
            slots[1] = pop ? 9'd0 : q[1];
            slots[2] = 9'd0;
            slots[3] = 9'd0;
            rem      = cnt_q - {1'b0, pop};
            cnt_nx   = {1'b0, rem};
            if (beat_vld) begin
                slots[rem] = {beat_sop, beat_data[7:0]};
                cnt_nx     = cnt_nx + 3'd1;
                if (beat_keep[1]) begin
                    slots[rem + 2'd1] = {1'b0, beat_data[15:8]};
                    cnt_nx            = cnt_nx + 3'd1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[0]       <= 9'd0;
                q[1]       <= 9'd0;
                cnt_q      <= 2'd0;
                eop_pend_q <= 1'b0;
                len_q      <= '0;
            end else begin
                q[0]  <= slots[0];
                q[1]  <= slots[1];
                cnt_q <= cnt_nx[1:0];
                if (end_pls) begin
                    eop_pend_q <= 1'b1;
                    len_q      <= end_len;
                end else if (eop_pend_q && cnt_q == 2'd0) begin
                    eop_pend_q <= 1'b0;
                end
            end
        end

        assign out_vld  = pop;
        assign out_data = q[0][7:0];
        assign out_keep = pop;
        assign out_sop  = pop & q[0][8];
        assign out_eop  = eop_pend_q && (cnt_q == 2'd0);
        assign out_len  = len_q;

        // R7: input-side assumption, the skid never has to hold more than two bytes
        a_r7_skid_room: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_nx <= 3'd2);

        // R9: a high byte is never offered without the low byte
        a_r9_keep_order: assert property (@(posedge clk) disable iff (!rst_n)
            beat_keep[1] |-> beat_keep[0]);
    end
endmodule

// File: rtl/rx_deformat.sv
module rx_deformat #(
    parameter int OUT_BYTES = 2,
    parameter int LEN_W     = 16,
    localparam int DW       = OUT_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           phy_ctl,
    input  logic [7:0]           phy_dlo,
    input  logic [7:0]           phy_dhi,
    input  logic                 phy_hvld,
    output logic                 out_vld,
    output logic [DW-1:0]        out_data,
    output logic [OUT_BYTES-1:0] out_keep,
    output logic                 out_sop,
    output logic                 out_eop,
    output logic [LEN_W-1:0]     out_len,
    output logic [2:0]           out_rate,
    output logic                 out_legacy,
    output logic                 st_vld,
    output logic [7:0]           st_byte,
    output logic                 out_err
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [1:0]       s_ctl, s_ctl_prev;
    logic [7:0]       s_lo, s_hi;
    logic             s_hv;
    logic             beat_vld, beat_sop, end_pls;
    logic [15:0]      beat_data;
    logic [1:0]       beat_keep;
    logic [LEN_W-1:0] end_len;

    rxd_sample u_sample (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_i      (phy_ctl),
        .lo_i       (phy_dlo),
        .hi_i       (phy_dhi),
        .hv_i       (phy_hvld),
        .ctl_q      (s_ctl),
        .ctl_prev_q (s_ctl_prev),
        .lo_q       (s_lo),
        .hi_q       (s_hi),
        .hv_q       (s_hv)
    );

    rxd_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_ctl      (s_ctl),
        .s_ctl_prev (s_ctl_prev),
        .s_lo       (s_lo),
        .s_hi       (s_hi),
        .s_hv       (s_hv),
        .beat_vld   (beat_vld),
        .beat_data  (beat_data),
        .beat_keep  (beat_keep),
        .beat_sop   (beat_sop),
        .end_pls    (end_pls),
        .end_len    (end_len),
        .rate_q     (out_rate),
        .legacy_q   (out_legacy),
        .stat_vld   (st_vld),
        .stat_byte  (st_byte),
        .err_pls    (out_err)
    );

    rxd_out #(.OUT_BYTES(OUT_BYTES), .LEN_W(LEN_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_vld  (beat_vld),
        .beat_data (beat_data),
        .beat_keep (beat_keep),
        .beat_sop  (beat_sop),
        .end_pls   (end_pls),
        .end_len   (end_len),
        .out_vld   (out_vld),
        .out_data  (out_data),
        .out_keep  (out_keep),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_len   (out_len)
    );
endmodule

// File: tb/rx_deformat_tb_top.sv
module rx_deformat_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  phy_ctl = 2'b00;
    logic [7:0]  phy_dlo = 8'h00;
    logic [7:0]  phy_dhi = 8'h00;
    logic        phy_hvld = 1'b0;
    logic        out_vld, out_sop, out_eop, out_legacy, st_vld, out_err;
    logic [15:0] out_data;
    logic [1:0]  out_keep;
    logic [15:0] out_len;
    logic [2:0]  out_rate;
    logic [7:0]  st_byte;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    rx_deformat dut_i (
        .clk(clk), .rst_n(rst_n), .phy_ctl(phy_ctl), .phy_dlo(phy_dlo),
        .phy_dhi(phy_dhi), .phy_hvld(phy_hvld), .out_vld(out_vld),
        .out_data(out_data), .out_keep(out_keep), .out_sop(out_sop),
        .out_eop(out_eop), .out_len(out_len), .out_rate(out_rate),
        .out_legacy(out_legacy), .st_vld(st_vld), .st_byte(st_byte),
        .out_err(out_err)
    );

    // row i holds the input for cycle i and the outputs expected from cycle i-2
    typedef struct packed {
        logic [1:0]  ctl;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic        hv;
        logic        ev;
        logic [15:0] ed;
        logic [1:0]  ek;
        logic        es;
        logic        ee;
        logic [7:0]  el;
        logic        sv;
        logic [7:0]  sb;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VT [NV] = '{
        '{2'b00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b10, 8'hFF, 8'h77, 1'b1, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b01, 8'h5A, 8'h77, 1'b1, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b10, 8'hFF, 8'h77, 1'b1, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b10, 8'h0B, 8'h77, 1'b1, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 8'd0, 1'b1, 8'h5A},
        '{2'b10, 8'h11, 8'h22, 1'b1, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b10, 8'h33, 8'h44, 1'b1, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b10, 8'h55, 8'hAA, 1'b0, 1'b1, 16'h2211, 2'b11, 1'b1, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b00, 8'h00, 8'h00, 1'b0, 1'b1, 16'h4433, 2'b11, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b00, 8'h00, 8'h00, 1'b0, 1'b1, 16'h0055, 2'b01, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b1, 8'd5, 1'b0, 8'h00},
        '{2'b10, 8'hFF, 8'h00, 1'b0, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b10, 8'h0D, 8'h00, 1'b0, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b10, 8'hA1, 8'hEE, 1'b1, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b10, 8'hA1, 8'hEE, 1'b1, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b10, 8'hB2, 8'h00, 1'b0, 1'b1, 16'h00A1, 2'b01, 1'b1, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b10, 8'hB2, 8'h00, 1'b0, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b00, 8'h00, 8'h00, 1'b0, 1'b1, 16'h00B2, 2'b01, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00},
        '{2'b00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b1, 8'd2, 1'b0, 8'h00},
        '{2'b00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, 8'd0, 1'b0, 8'h00}
    };

    // output monitor for the directed part
    logic [7:0]  log_b [64];
    int          log_n = 0, eop_n = 0, err_n = 0, st_n = 0, sop_n = 0;
    logic [15:0] last_len = 16'h0;
    bit          mon_on = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (out_vld) begin
                if (out_sop) sop_n++;
                if (log_n < 64) log_b[log_n] = out_data[7:0];
                log_n++;
                if (out_keep[1]) begin
                    if (log_n < 64) log_b[log_n] = out_data[15:8];
                    log_n++;
                end
            end
            if (out_eop) begin eop_n++; last_len = out_len; end
            if (out_err) err_n++;
            if (st_vld)  st_n++;
        end
    end

    task automatic check(input string tag, input bit ok, input string act, input string exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] c, input logic [7:0] l, input logic [7:0] h, input logic v);
        @(negedge clk);
        phy_ctl = c; phy_dlo = l; phy_dhi = h; phy_hvld = v;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(2'b00, 8'h00, 8'h00, 1'b0);
    endtask

    task automatic clear_mon();
        log_n = 0; eop_n = 0; err_n = 0; st_n = 0; sop_n = 0; last_len = 16'h0;
    endtask

    // open a reception, send rate code, nb bytes each held rep cycles, then close
    task automatic run_pkt(input logic [7:0] code, input int rep, input int nb, input logic [7:0] base);
        idle(2);
        clear_mon();
        drive(2'b10, 8'hFF, 8'h00, 1'b0);
        drive(2'b10, code, 8'h00, 1'b0);
        for (int b = 0; b < nb; b++)
            for (int r = 0; r < rep; r++)
                drive(2'b10, base + 8'(b), 8'h5C, 1'b1);
        idle(5);
    endtask

    task automatic check_pkt(input string tag, input int nb, input logic [7:0] base,
                             input logic [2:0] rate, input logic leg);
        bit ok;
        ok = (log_n == nb) && (eop_n == 1) && (last_len == 16'(nb)) && (sop_n == 1);
        for (int b = 0; b < nb && b < 64; b++) if (log_b[b] != base + 8'(b)) ok = 1'b0;
        check({tag, " bytes/len"}, ok,
              $sformatf("n=%0d eop=%0d len=%0d sop=%0d", log_n, eop_n, last_len, sop_n),
              $sformatf("n=%0d eop=1 len=%0d sop=1", nb, nb));
        check({tag, " rate"}, (out_rate == rate) && (out_legacy == leg),
              $sformatf("rate=%0d leg=%0d", out_rate, out_legacy),
              $sformatf("rate=%0d leg=%0d", rate, leg));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog actual=done0 expected=done1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 reset", {out_vld, out_sop, out_eop, out_err, st_vld, out_rate, out_legacy} == 9'd0,
              $sformatf("%b", {out_vld, out_sop, out_eop, out_err, st_vld, out_rate, out_legacy}),
              "000000000");
        rst_n = 1'b1;
        idle(2);

        // table: R3 R7 R8 R9 R10 R11 R6 (paired packet with status, then a 2-cycle-group packet)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            begin
                vec_t v;
                logic [15:0] km;
                bit ok;
                v  = VT[i];
                km = {{8{v.ek[1]}}, {8{v.ek[0]}}};
                ok = (out_vld == v.ev) && (out_eop == v.ee) && (st_vld == v.sv);
                if (v.ev) ok = ok && (out_keep == v.ek) && (out_sop == v.es) && ((out_data & km) == (v.ed & km));
                if (v.ee) ok = ok && (out_len == 16'(v.el));
                if (v.sv) ok = ok && (st_byte == v.sb);
                check($sformatf("R3 R7 R8 R9 R10 R11 table row %0d", i), ok,
                      $sformatf("vld=%b d=%h k=%b sop=%b eop=%b len=%0d st=%b/%h",
                                out_vld, out_data, out_keep, out_sop, out_eop, out_len, st_vld, st_byte),
                      $sformatf("vld=%b d=%h k=%b sop=%b eop=%b len=%0d st=%b/%h",
                                v.ev, v.ed, v.ek, v.es, v.ee, v.el, v.sv, v.sb));
                phy_ctl = v.ctl; phy_dlo = v.lo; phy_dhi = v.hi; phy_hvld = v.hv;
            end
        end
        check("R4 rate after table", (out_rate == 3'd3) && (out_legacy == 1'b0),
              $sformatf("rate=%0d leg=%0d", out_rate, out_legacy), "rate=3 leg=0");

        mon_on = 1'b1;

        // R5: reserved rate code
        idle(2); clear_mon();
        drive(2'b10, 8'hFF, 8'h00, 1'b0);
        drive(2'b10, 8'h03, 8'h00, 1'b0);
        for (int k = 0; k < 3; k++) drive(2'b10, 8'h44, 8'h44, 1'b1);
        idle(5);
        check("R5 reserved code", (err_n == 1) && (log_n == 0) && (eop_n == 0),
              $sformatf("err=%0d beats=%0d eop=%0d", err_n, log_n, eop_n), "err=1 beats=0 eop=0");

        // R6 R4: each rate code with its group length
        run_pkt(8'h00, 16, 2, 8'hC3); check_pkt("R6 R4 code00", 2, 8'hC3, 3'd0, 1'b1);
        run_pkt(8'h01, 16, 2, 8'h10); check_pkt("R6 R4 code01", 2, 8'h10, 3'd0, 1'b0);
        run_pkt(8'h04,  8, 3, 8'h20); check_pkt("R6 R4 code04", 3, 8'h20, 3'd1, 1'b1);
        run_pkt(8'h05,  8, 2, 8'h9A); check_pkt("R6 R4 code05", 2, 8'h9A, 3'd1, 1'b0);
        run_pkt(8'h08,  4, 3, 8'h55); check_pkt("R6 R4 code08", 3, 8'h55, 3'd2, 1'b1);
        run_pkt(8'h09,  4, 3, 8'h11); check_pkt("R6 R4 code09", 3, 8'h11, 3'd2, 1'b0);
        run_pkt(8'h0F,  1, 4, 8'h01); check_pkt("R6 R4 code0F", 4, 8'h01, 3'd4, 1'b0);

        // R9: one-byte paired packet with the high lane marked invalid
        idle(2); clear_mon();
        drive(2'b10, 8'hFF, 8'h00, 1'b0);
        drive(2'b10, 8'h0B, 8'h00, 1'b0);
        drive(2'b10, 8'hA5, 8'h99, 1'b0);
        idle(5);
        check("R9 single byte", (log_n == 1) && (log_b[0] == 8'hA5) && (eop_n == 1) && (last_len == 16'd1),
              $sformatf("n=%0d b0=%h eop=%0d len=%0d", log_n, log_b[0], eop_n, last_len),
              "n=1 b0=a5 eop=1 len=1");
        check("R4 paired rate", out_rate == 3'd5, $sformatf("%0d", out_rate), "5");

        // R2: receive code without the marker from idle
        idle(2); clear_mon();
        drive(2'b10, 8'h42, 8'h00, 1'b0);
        drive(2'b10, 8'h43, 8'h00, 1'b0);
        drive(2'b01, 8'h44, 8'h00, 1'b0);
        drive(2'b10, 8'hFF, 8'h00, 1'b0);
        drive(2'b10, 8'h0F, 8'h00, 1'b0);
        idle(5);
        check("R2 no marker", (log_n == 0) && (eop_n == 0) && (st_n == 0) && (err_n == 0),
              $sformatf("beats=%0d eop=%0d st=%0d err=%0d", log_n, eop_n, st_n, err_n),
              "beats=0 eop=0 st=0 err=0");

        // R12: header abandoned before a rate code
        idle(2); clear_mon();
        drive(2'b10, 8'hFF, 8'h00, 1'b0);
        drive(2'b01, 8'h77, 8'h00, 1'b0);
        idle(5);
        check("R12 header abort", (st_n == 1) && (eop_n == 0) && (err_n == 0) && (log_n == 0),
              $sformatf("st=%0d eop=%0d err=%0d beats=%0d", st_n, eop_n, err_n, log_n),
              "st=1 eop=0 err=0 beats=0");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule